// File: doc/BRIEF.md
# Byte-Serial CRC-32 Engine (MSB-first, polynomial 0x20044009)

This block folds a stream of bytes into a 32-bit cyclic redundancy check at one byte per clock. It uses the generator x^32 + x^29 + x^18 + x^14 + x^3 + 1 (0x20044009) and shifts data in most-significant bit first. There is no input or output reflection and no final complement, so the checksum register is presented on the output as is.

A host pulses a start strobe to seed the register from a programmable value, which is normally 0xFFFFFFFF. It then presents bytes with a valid qualifier. The result output can be sampled at any time and reflects every byte accepted so far. If a byte arrives in the same cycle as the start strobe, that byte is folded into the seed value. Framing, length tracking and any post-processing of the result belong to the surrounding logic.

A parameter selects how a byte is folded in. One option is a 256-entry lookup table generated from the polynomial at elaboration time. The other is an unrolled shift-and-XOR network. Both options produce identical results.

Top module: `crc32_byte_engine`

## Requirements
- R1: While the synchronous active-high reset is asserted, the register loads 0xFFFFFFFF, and crc_o shows that value after the reset edge.
- R2: A start strobe without a valid byte loads init_i into the register, and the value is visible on crc_o after that clock edge.
- R3: An accepted byte b updates register c to (c << 8) XOR T[c[31:24] XOR b]. T[i] is obtained by placing i in bits 31:24 of an otherwise zero word and then performing eight steps. Each step shifts left by one and XORs in 0x20044009 when the bit shifted out was 1. A zero register with a zero byte stays zero.
- R4: Starting from 0xFFFFFFFF, the bytes 0x01, 0x02, 0x03, 0x04 leave 0xF33CB7D3 on crc_o.
- R5: In a cycle with neither start_i nor vld_i asserted, the register keeps its value.
- R6: When start_i and vld_i are both asserted in one cycle, the byte is folded into init_i, and the previous register contents are discarded.
- R7: crc_o is the raw register with no inversion or bit reversal. It changes only on the clock edge after a cycle in which start_i or vld_i was asserted.
- R8: The table-based variant (USE_TABLE=1) and the XOR-network variant (USE_TABLE=0) give identical crc_o for identical stimulus.
- R9: A single byte b folded into a zero seed yields exactly T[b] for every one of the 256 byte values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Seed strobe that loads init_i |
| init_i | input | 32 | Seed value used with start_i |
| vld_i | input | 1 | Byte qualifier |
| byte_i | input | 8 | Data byte, folded in when vld_i is high |
| crc_o | output | 32 | Current checksum register |

## Verification
The hardest case to reach from the ports is a start strobe and a byte arriving in the same cycle after the register already holds unrelated history. Only this case shows whether the old contents leak into the fold. The bench first runs a multi-byte stream to build up a non-trivial register value. It then issues the combined strobe for every one of the 256 byte values, using both a zero seed and an all-ones seed. It compares two instances, one of each variant, against a bitwise model after every edge.

// File: rtl/crc_pkg.sv
package crc_pkg;
    localparam int CRC_W  = 32;
    localparam int BYTE_W = 8;
    localparam logic [CRC_W-1:0] DEF_POLY = 32'h2004_4009;
    localparam logic [CRC_W-1:0] DEF_SEED = 32'hFFFF_FFFF;

    typedef struct packed {
        logic [CRC_W-1:0] crc;
    } crc_state_t;

    // Remainder of one index value after BYTE_W MSB-first division steps
    function automatic logic [CRC_W-1:0] tab_entry(
        input logic [BYTE_W-1:0] idx,
        input logic [CRC_W-1:0]  poly
    );
        logic [CRC_W-1:0] r;
        r = {idx, {(CRC_W-BYTE_W){1'b0}}};
        for (int k = 0; k < BYTE_W; k++) begin
            if (r[CRC_W-1]) r = (r << 1) ^ poly;
            else            r = r << 1;
        end
        return r;
    endfunction
endpackage

// File: rtl/crc_table_rom.sv
module crc_table_rom
    import crc_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = DEF_POLY
) (
    input  logic [BYTE_W-1:0] idx_i,
    output logic [CRC_W-1:0]  entry_o
);
    localparam int ENTRIES = 1 << BYTE_W;

    logic [CRC_W-1:0] tab [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_tab
        assign tab[g] = tab_entry(BYTE_W'(g), POLY);
    end

    assign entry_o = tab[idx_i];
endmodule

// File: rtl/crc_byte_step.sv
module crc_byte_step
    import crc_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY      = DEF_POLY,
    parameter bit               USE_TABLE = 1'b1
) (
    input  logic [CRC_W-1:0]  seed_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [CRC_W-1:0]  crc_o
);
    localparam int TOP = CRC_W - BYTE_W;

    if (USE_TABLE) begin : g_table
        logic [BYTE_W-1:0] idx;
        logic [CRC_W-1:0]  entry;

        assign idx = seed_i[CRC_W-1:TOP] ^ byte_i;

        crc_table_rom #(.POLY(POLY)) u_rom (
            .idx_i  (idx),
            .entry_o(entry)
        );

        assign crc_o = (seed_i << BYTE_W) ^ entry;
    end else begin : g_xor
        always_comb begin
            logic [CRC_W-1:0] r;
            r = seed_i ^ {byte_i, {TOP{1'b0}}};
            for (int k = 0; k < BYTE_W; k++) begin
                if (r[CRC_W-1]) r = (r << 1) ^ POLY;
                else            r = r << 1;
            end
            crc_o = r;
        end
    end

    // R3
    always_comb begin
        if (seed_i == '0 && byte_i == '0) begin
            zero_fold_chk: assert (crc_o == '0);
        end
    end
endmodule

// File: rtl/crc32_byte_engine.sv
module crc32_byte_engine
    import crc_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY      = DEF_POLY,
    parameter logic [CRC_W-1:0] RESET_VAL = DEF_SEED,
    parameter bit               USE_TABLE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [CRC_W-1:0]  init_i,
    input  logic              vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [CRC_W-1:0]  crc_o
);
    crc_state_t       st_d, st_q;
    logic [CRC_W-1:0] seed;
    logic [CRC_W-1:0] folded;

    assign seed = start_i ? init_i : st_q.crc;

    crc_byte_step #(.POLY(POLY), .USE_TABLE(USE_TABLE)) u_step (
        .seed_i(seed),
        .byte_i(byte_i),
        .crc_o (folded)
    );

    always_comb begin
        st_d = st_q;
        if (vld_i)        st_d.crc = folded;
        else if (start_i) st_d.crc = init_i;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q.crc <= RESET_VAL;
        else     st_q     <= st_d;
    end

    assign crc_o = st_q.crc;

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !vld_i) |=> $stable(crc_o));

    // R2
    seed_load_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !vld_i) |=> (crc_o == $past(init_i)));

    // R7
    change_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(crc_o) |-> $past(start_i || vld_i));
endmodule

// File: tb/sim_crc32_byte_engine.sv
module sim_crc32_byte_engine;
    localparam logic [31:0] POLY = 32'h2004_4009;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [31:0] init_i;
    logic        vld_i;
    logic [7:0]  byte_i;
    logic [31:0] crc_t, crc_x;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    logic [31:0] model;

    always #2.5 clk = ~clk;

    crc32_byte_engine #(.USE_TABLE(1'b1)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .init_i(init_i),
        .vld_i(vld_i), .byte_i(byte_i), .crc_o(crc_t)
    );

    crc32_byte_engine #(.USE_TABLE(1'b0)) u1 (
        .clk(clk), .rst(rst), .start_i(start_i), .init_i(init_i),
        .vld_i(vld_i), .byte_i(byte_i), .crc_o(crc_x)
    );

    function automatic logic [31:0] ref_fold(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {b, 24'h0};
        for (int k = 0; k < 8; k++) r = r[31] ? ((r << 1) ^ POLY) : (r << 1);
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Apply one cycle of stimulus, then sample both variants after the edge
    task automatic step(input logic s, input logic [31:0] ini, input logic v, input logic [7:0] b,
                        input string req);
        @(negedge clk);
        start_i = s; init_i = ini; vld_i = v; byte_i = b;
        if (v)      model = ref_fold(s ? ini : model, b);
        else if (s) model = ini;
        @(posedge clk);
        #1;
        check(req, crc_t, model);
        check("R8", crc_x, crc_t);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; start_i = 1'b0; init_i = '0; vld_i = 1'b0; byte_i = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset value
        check("R1", crc_t, 32'hFFFF_FFFF);
        check("R1", crc_x, 32'hFFFF_FFFF);
        @(negedge clk);
        rst = 1'b0;
        model = 32'hFFFF_FFFF;

        // R4 reference vector, first byte combined with the seed strobe (R6)
        step(1'b1, 32'hFFFF_FFFF, 1'b1, 8'h01, "R6");
        step(1'b0, 32'h0, 1'b1, 8'h02, "R3");
        step(1'b0, 32'h0, 1'b1, 8'h03, "R3");
        step(1'b0, 32'h0, 1'b1, 8'h04, "R3");
        check("R4", crc_t, 32'hF33C_B7D3);

        // R5: idle cycles hold, even with junk on byte_i and init_i
        for (int k = 0; k < 4; k++) step(1'b0, 32'hDEAD_BEEF, 1'b0, 8'hA5, "R5");
        check("R5", crc_t, 32'hF33C_B7D3);

        // R7: output unchanged before the edge that accepts a byte
        @(negedge clk);
        start_i = 1'b0; vld_i = 1'b1; byte_i = 8'h3C;
        #1;
        check("R7", crc_t, 32'hF33C_B7D3);
        model = ref_fold(model, 8'h3C);
        @(posedge clk);
        #1;
        check("R7", crc_t, model);
        check("R7", crc_t ^ 32'hFFFF_FFFF, ~model);

        // R2: seed load without a byte
        step(1'b1, 32'h1234_5678, 1'b0, 8'h77, "R2");
        check("R2", crc_t, 32'h1234_5678);
        step(1'b1, 32'h0, 1'b0, 8'h00, "R2");

        // R9 + R3: each byte from a zero seed, previous history discarded (R6)
        for (int b = 0; b < 256; b++) begin
            step(1'b0, 32'h0, 1'b1, 8'(b * 37 + 11), "R3");
            step(1'b1, 32'h0, 1'b1, 8'(b), "R9");
        end

        // R6 + R3: every byte as first byte from all-ones seed, then a stream
        for (int b = 0; b < 256; b++) begin
            step(1'b1, 32'hFFFF_FFFF, 1'b1, 8'(b), "R6");
            step(1'b0, 32'h0, 1'b1, 8'(b ^ 8'h5A), "R3");
            step(1'b0, 32'h0, 1'b0, 8'(b), "R5");
            step(1'b0, 32'h0, 1'b1, 8'(255 - b), "R3");
        end

        // R1: reset mid-stream returns to all ones
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1", crc_t, 32'hFFFF_FFFF);
        check("R1", crc_x, 32'hFFFF_FFFF);
        @(negedge clk);
        rst = 1'b0; vld_i = 1'b0; start_i = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule